// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Engine

This block holds the data side of SMBus and I2C block transfers. It sits between the software-visible host registers and the bus sequencer. It keeps a 32-entry byte buffer, a buffer index, the block byte count and a one-byte holding register. Bytes go to the sequencer on a valid/ready transmit channel and come back on a valid/ready receive channel. The block does no bus signalling of its own. For I2C block reads it raises a one-cycle `stop_o` request, and the sequencer answers it with a NACK and a stop condition.

Software picks one of two transfer styles when it starts an operation:

- **Buffered mode.** The whole block passes through the buffer. Software loads it before a write, or empties it after a read, through the block data port.
- **Byte-by-byte mode.** Each byte passes through the holding register. Software paces every byte by clearing the byte-done flag.

An I2C block read always runs byte by byte. Starting a new operation while one is unfinished abandons the old one.

The controller is a state machine with eight states:

- `ST_IDLE`: no operation is in progress. The block data port and the count register are open to software.
- `ST_TX_SEND`: the buffer is streamed to the sequencer.
- `ST_RX_FILL`: received bytes are stored into the buffer.
- `ST_DRAIN`: software reads out a filled buffer.
- `ST_BW_HOLD`: a byte-by-byte write waits for software to clear byte done.
- `ST_BR_FETCH`: a byte-by-byte read waits for the next byte from the sequencer.
- `ST_BR_HOLD`: a fetched byte waits for software to clear byte done.
- `ST_BR_FINAL`: the last byte of a byte-by-byte read is awaited.

The transitions are as follows:

- A start pulse leaves any state. It goes to `ST_TX_SEND`, `ST_RX_FILL`, `ST_BW_HOLD` or `ST_BR_FETCH`, or back to `ST_IDLE` on a count mismatch.
- `ST_TX_SEND` goes to `ST_IDLE` on acceptance of the last byte.
- `ST_RX_FILL` goes to `ST_DRAIN` on a byte flagged last.
- `ST_DRAIN` goes to `ST_IDLE` on the count-th port read.
- `ST_BW_HOLD` goes to `ST_TX_SEND` when the advanced index equals the count.
- `ST_BR_FETCH` goes to `ST_BR_HOLD` on a received byte.
- `ST_BR_HOLD` goes to `ST_BR_FETCH` on a clear with the last-byte flag low, or to `ST_BR_FINAL` on a clear with it high.
- `ST_BR_FINAL` goes to `ST_IDLE` on a received byte.

Top module: `smb_blk_engine`

## Requirements
- R1: After reset the following are all low: busy, byte done, done, device error, `tx_valid_o`, `rx_ready_o` and `stop_o`. The count reads 0.
- R2: In buffered mode (`buffered_i`=1, `read_i`=0, `i2c_rd_i`=0), each block data write in idle stores the byte at the index and increments the index. A start with the index equal to the count streams entries 0 to count-1 in order on the transmit channel, with `tx_last_o` high only on the final byte. After the final byte, done is 1 and busy is 0.
- R3: A buffered-mode write started with the index different from the count sends nothing. It sets device error, leaves busy low and resets the index to 0.
- R4: A buffered read (`buffered_i`=1, `read_i`=1) stores received bytes from entry 0 until a byte flagged `rx_last_i`. It then sets the count to the number of bytes received and sets done, while busy stays 1. Each block data read returns the entry at the index and advances the index. The read that reaches the count clears busy.
- R5: A byte-by-byte write (`buffered_i`=0, `read_i`=0) copies the holding byte to entry 0 on start and sets busy and byte done. Each byte-done clear advances the index and stores the holding byte there. When the advanced index equals the count, the block is sent, then done is set and busy cleared.
- R6: A byte-by-byte read (`read_i`=1 with `buffered_i`=0, or any start with `i2c_rd_i`=1) fetches one byte per step into the holding register, which the block data port returns, and sets byte done. A clear with `last_byte_i` low fetches the next byte.
- R7: A clear with `last_byte_i` high fetches one final byte. It then sets done, clears busy and resets the index. For an I2C block read, `stop_o` pulses in the cycle the final byte is accepted. For other reads it stays low.
- R8: A start while an operation is unfinished abandons that operation and resets the index to 0. If an I2C block read was open, `stop_o` pulses in the cycle of the start.
- R9: A block data port access finding the index at 32 wraps it to 0 first, so a 33rd consecutive write overwrites entry 0.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, the transmit byte and last flag hold steady.
- R11: Count writes are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start of an operation |
| buffered_i | input | 1 | 1 selects buffered mode, 0 byte-by-byte mode |
| read_i | input | 1 | 1 for a read operation |
| i2c_rd_i | input | 1 | 1 for an I2C block read (always byte by byte) |
| last_byte_i | input | 1 | Next byte-done clear finishes a read |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 8 | Count write value |
| blk_we_i | input | 1 | Block data port write strobe |
| blk_wdata_i | input | 8 | Block data port write value |
| blk_re_i | input | 1 | Block data port read strobe |
| blk_rdata_o | output | 8 | Block data port read value |
| bd_clr_i | input | 1 | Software clears byte done |
| busy_o | output | 1 | Operation unfinished |
| byte_done_o | output | 1 | Byte handed off, awaiting software |
| done_o | output | 1 | Operation completed |
| dev_err_o | output | 1 | Start refused |
| count_o | output | 8 | Block byte count |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Transmit byte is the last |
| tx_ready_i | input | 1 | Sequencer accepts the transmit byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_last_i | input | 1 | Received byte ends a buffered read |
| rx_ready_o | output | 1 | Engine accepts a received byte |
| stop_o | output | 1 | Request NACK and stop for an I2C block read |

## Verification
Every software strobe and every receive handshake acts on the next rising edge. The resulting status, count, index and holding byte can therefore be seen one cycle later. The bench drives each strobe on a falling edge and removes it on the following falling edge, where it also samples the registered results. `tx_valid_o`, `tx_data_o`, `tx_last_o`, `rx_ready_o` and `blk_rdata_o` follow the current state and index without delay. `stop_o` is combinational on the accepting handshake or the aborting start, so the bench samples it 1 ns after driving that input and before the edge. Transmitted bytes are recorded on each falling edge where valid and ready are both high, which is the edge before the byte is consumed.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_SEND,
        ST_RX_FILL,
        ST_DRAIN,
        ST_BW_HOLD,
        ST_BR_FETCH,
        ST_BR_HOLD,
        ST_BR_FINAL
    } xfer_state_e;

    typedef enum logic [1:0] {
        KIND_BR,
        KIND_FILL,
        KIND_BUF_TX,
        KIND_BW
    } start_kind_e;

    function automatic start_kind_e classify_start(
        input logic buffered,
        input logic rd,
        input logic i2c_rd
    );
        if (i2c_rd || (!buffered && rd)) begin
            return KIND_BR;
        end else if (buffered && rd) begin
            return KIND_FILL;
        end else if (buffered) begin
            return KIND_BUF_TX;
        end
        return KIND_BW;
    endfunction

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] entry_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == AW'(e))) begin
                entry_q[e] <= wdata_i;
            end
        end
    end

    assign rdata_o = entry_q[raddr_i];

endmodule

// File: rtl/smb_blk_ctrl.sv
module smb_blk_ctrl
    import smb_blk_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int CW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          buffered_i,
    input  logic          read_i,
    input  logic          i2c_rd_i,
    input  logic          last_byte_i,
    input  logic          cnt_we_i,
    input  logic [CW-1:0] cnt_wdata_i,
    input  logic          blk_we_i,
    input  logic [DW-1:0] blk_wdata_i,
    input  logic          blk_re_i,
    input  logic          bd_clr_i,
    input  logic          tx_ready_i,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_last_i,
    input  logic [DW-1:0] buf_rdata_i,
    output logic          buf_we_o,
    output logic [AW-1:0] buf_waddr_o,
    output logic [DW-1:0] buf_wdata_o,
    output logic [AW-1:0] buf_raddr_o,
    output logic [DW-1:0] blk_rdata_o,
    output logic          busy_o,
    output logic          byte_done_o,
    output logic          done_o,
    output logic          dev_err_o,
    output logic [CW-1:0] count_o,
    output logic          tx_valid_o,
    output logic          tx_last_o,
    output logic          rx_ready_o,
    output logic          stop_o
);

    xfer_state_e state_q, state_d;

    logic [IW-1:0] idx_q, idx_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] hold_q, hold_d;
    logic          busy_q, busy_d;
    logic          bd_q, bd_d;
    logic          done_q, done_d;
    logic          err_q, err_d;
    logic          i2c_q, i2c_d;

    logic [IW-1:0] idx_eff;
    logic [IW-1:0] idx_inc;
    logic [IW-1:0] idx_step;
    logic [IW-1:0] idx_step_w;
    logic [IW-1:0] idx_base;
    logic          br_state;
    logic          unfinished;
    logic          stop_c;
    logic          we_c;
    logic [AW-1:0] waddr_c;
    logic [DW-1:0] wdata_c;
    start_kind_e   kind;

    function automatic logic [IW-1:0] wrap_idx(input logic [IW-1:0] v);
        return (v >= IW'(DEPTH)) ? '0 : v;
    endfunction

    assign idx_eff    = wrap_idx(idx_q);
    assign idx_inc    = idx_eff + 1'b1;
    assign idx_step   = idx_q + 1'b1;
    assign idx_step_w = wrap_idx(idx_step);
    assign br_state   = (state_q == ST_BR_FETCH) || (state_q == ST_BR_HOLD) ||
                        (state_q == ST_BR_FINAL);
    assign unfinished = (state_q != ST_IDLE);
    assign idx_base   = unfinished ? '0 : idx_q;
    assign kind       = classify_start(buffered_i, read_i, i2c_rd_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath updates
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        hold_d  = hold_q;
        busy_d  = busy_q;
        bd_d    = bd_q;
        done_d  = done_q;
        err_d   = err_q;
        i2c_d   = i2c_q;
        stop_c  = 1'b0;
        we_c    = 1'b0;
        waddr_c = idx_eff[AW-1:0];
        wdata_c = blk_wdata_i;

        unique case (state_q)
            ST_IDLE: begin
                if (blk_we_i) begin
                    if (buffered_i) begin
                        we_c  = 1'b1;
                        idx_d = idx_inc;
                    end else begin
                        hold_d = blk_wdata_i;
                    end
                end
                if (blk_re_i && buffered_i) begin
                    idx_d = idx_inc;
                end
                if (cnt_we_i) begin
                    cnt_d = cnt_wdata_i;
                end
            end
            ST_TX_SEND: begin
                if (tx_ready_i) begin
                    if (CW'(idx_inc) == cnt_q) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                        busy_d  = 1'b0;
                        done_d  = 1'b1;
                    end else begin
                        idx_d = idx_inc;
                    end
                end
            end
            ST_RX_FILL: begin
                if (rx_valid_i) begin
                    we_c    = 1'b1;
                    wdata_c = rx_data_i;
                    idx_d   = idx_inc;
                    if (rx_last_i) begin
                        cnt_d   = CW'(idx_inc);
                        idx_d   = '0;
                        done_d  = 1'b1;
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (blk_re_i) begin
                    if (CW'(idx_inc) == cnt_q) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                        busy_d  = 1'b0;
                    end else begin
                        idx_d = idx_inc;
                    end
                end
            end
            ST_BW_HOLD: begin
                if (blk_we_i) begin
                    hold_d = blk_wdata_i;
                end
                if (bd_clr_i) begin
                    bd_d = 1'b0;
                    if (CW'(idx_step) == cnt_q) begin
                        idx_d   = '0;
                        state_d = ST_TX_SEND;
                    end else begin
                        idx_d   = idx_step_w;
                        we_c    = 1'b1;
                        waddr_c = idx_step_w[AW-1:0];
                        wdata_c = hold_q;
                        bd_d    = 1'b1;
                    end
                end
            end
            ST_BR_FETCH: begin
                if (rx_valid_i) begin
                    hold_d  = rx_data_i;
                    bd_d    = 1'b1;
                    state_d = ST_BR_HOLD;
                end
            end
            ST_BR_HOLD: begin
                if (bd_clr_i) begin
                    bd_d    = 1'b0;
                    idx_d   = idx_step_w;
                    state_d = last_byte_i ? ST_BR_FINAL : ST_BR_FETCH;
                end
            end
            ST_BR_FINAL: begin
                if (rx_valid_i) begin
                    hold_d  = rx_data_i;
                    done_d  = 1'b1;
                    busy_d  = 1'b0;
                    idx_d   = '0;
                    stop_c  = i2c_q;
                    state_d = ST_IDLE;
                end
            end
        endcase

        if (start_i) begin
            we_c   = 1'b0;
            stop_c = br_state && i2c_q;
            done_d = 1'b0;
            err_d  = 1'b0;
            bd_d   = 1'b0;
            i2c_d  = i2c_rd_i;
            idx_d  = '0;
            unique case (kind)
                KIND_BR: begin
                    busy_d  = 1'b1;
                    state_d = ST_BR_FETCH;
                end
                KIND_FILL: begin
                    busy_d  = 1'b1;
                    state_d = ST_RX_FILL;
                end
                KIND_BUF_TX: begin
                    if (CW'(idx_base) != cnt_q) begin
                        err_d   = 1'b1;
                        busy_d  = 1'b0;
                        state_d = ST_IDLE;
                    end else if (cnt_q == '0) begin
                        done_d  = 1'b1;
                        busy_d  = 1'b0;
                        state_d = ST_IDLE;
                    end else begin
                        busy_d  = 1'b1;
                        state_d = ST_TX_SEND;
                    end
                end
                KIND_BW: begin
                    we_c    = 1'b1;
                    waddr_c = '0;
                    wdata_c = hold_q;
                    busy_d  = 1'b1;
                    bd_d    = 1'b1;
                    state_d = ST_BW_HOLD;
                end
            endcase
        end
    end

    // datapath and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cnt_q  <= '0;
            hold_q <= '0;
            busy_q <= 1'b0;
            bd_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            i2c_q  <= 1'b0;
        end else begin
            idx_q  <= idx_d;
            cnt_q  <= cnt_d;
            hold_q <= hold_d;
            busy_q <= busy_d;
            bd_q   <= bd_d;
            done_q <= done_d;
            err_q  <= err_d;
            i2c_q  <= i2c_d;
        end
    end

    // outputs
    always_comb begin
        tx_valid_o  = (state_q == ST_TX_SEND);
        tx_last_o   = tx_valid_o && (CW'(idx_inc) == cnt_q);
        rx_ready_o  = (state_q == ST_RX_FILL) || (state_q == ST_BR_FETCH) ||
                      (state_q == ST_BR_FINAL);
        blk_rdata_o = (!buffered_i || br_state) ? hold_q : buf_rdata_i;
        buf_we_o    = we_c;
        buf_waddr_o = waddr_c;
        buf_wdata_o = wdata_c;
        buf_raddr_o = idx_eff[AW-1:0];
        busy_o      = busy_q;
        byte_done_o = bd_q;
        done_o      = done_q;
        dev_err_o   = err_q;
        count_o     = cnt_q;
        stop_o      = stop_c;
    end

endmodule

// File: rtl/smb_blk_engine.sv
module smb_blk_engine #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          buffered_i,
    input  logic          read_i,
    input  logic          i2c_rd_i,
    input  logic          last_byte_i,
    input  logic          cnt_we_i,
    input  logic [DW-1:0] cnt_wdata_i,
    input  logic          blk_we_i,
    input  logic [DW-1:0] blk_wdata_i,
    input  logic          blk_re_i,
    output logic [DW-1:0] blk_rdata_o,
    input  logic          bd_clr_i,
    output logic          busy_o,
    output logic          byte_done_o,
    output logic          done_o,
    output logic          dev_err_o,
    output logic [DW-1:0] count_o,
    output logic          tx_valid_o,
    output logic [DW-1:0] tx_data_o,
    output logic          tx_last_o,
    input  logic          tx_ready_i,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_last_i,
    output logic          rx_ready_o,
    output logic          stop_o
);

    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [DW-1:0] buf_wdata;
    logic [AW-1:0] buf_raddr;
    logic [DW-1:0] buf_rdata;

    smb_blk_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (buf_waddr),
        .wdata_i (buf_wdata),
        .raddr_i (buf_raddr),
        .rdata_o (buf_rdata)
    );

    smb_blk_ctrl #(.DEPTH(DEPTH), .DW(DW), .CW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .buffered_i  (buffered_i),
        .read_i      (read_i),
        .i2c_rd_i    (i2c_rd_i),
        .last_byte_i (last_byte_i),
        .cnt_we_i    (cnt_we_i),
        .cnt_wdata_i (cnt_wdata_i),
        .blk_we_i    (blk_we_i),
        .blk_wdata_i (blk_wdata_i),
        .blk_re_i    (blk_re_i),
        .bd_clr_i    (bd_clr_i),
        .tx_ready_i  (tx_ready_i),
        .rx_valid_i  (rx_valid_i),
        .rx_data_i   (rx_data_i),
        .rx_last_i   (rx_last_i),
        .buf_rdata_i (buf_rdata),
        .buf_we_o    (buf_we),
        .buf_waddr_o (buf_waddr),
        .buf_wdata_o (buf_wdata),
        .buf_raddr_o (buf_raddr),
        .blk_rdata_o (blk_rdata_o),
        .busy_o      (busy_o),
        .byte_done_o (byte_done_o),
        .done_o      (done_o),
        .dev_err_o   (dev_err_o),
        .count_o     (count_o),
        .tx_valid_o  (tx_valid_o),
        .tx_last_o   (tx_last_o),
        .rx_ready_o  (rx_ready_o),
        .stop_o      (stop_o)
    );

    assign tx_data_o = buf_rdata;

endmodule

// File: rtl/smb_blk_engine_chk.sv
module smb_blk_engine_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rx_valid_i,
    input logic          tx_ready_i,
    input logic          busy_o,
    input logic          byte_done_o,
    input logic          dev_err_o,
    input logic [DW-1:0] count_o,
    input logic          tx_valid_o,
    input logic [DW-1:0] tx_data_o,
    input logic          tx_last_o,
    input logic          rx_ready_o,
    input logic          stop_o
);

    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !start_i) |=>
            (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

    a_r11_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rx_ready_o) |=> $stable(count_o));

    a_r5_bd_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |-> busy_o);

    a_r3_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_err_o) |-> (!busy_o && !tx_valid_o));

    a_r7_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> ((rx_valid_i && rx_ready_o) || start_i));

    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid_o && rx_ready_o));

endmodule

bind smb_blk_engine smb_blk_engine_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rx_valid_i  (rx_valid_i),
    .tx_ready_i  (tx_ready_i),
    .busy_o      (busy_o),
    .byte_done_o (byte_done_o),
    .dev_err_o   (dev_err_o),
    .count_o     (count_o),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_last_o   (tx_last_o),
    .rx_ready_o  (rx_ready_o),
    .stop_o      (stop_o)
);

// File: tb/smb_blk_engine_tb.sv
`timescale 1ns/1ps
module smb_blk_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, buffered_i = 1'b0, read_i = 1'b0, i2c_rd_i = 1'b0;
    logic       last_byte_i = 1'b0, cnt_we_i = 1'b0, blk_we_i = 1'b0, blk_re_i = 1'b0;
    logic       bd_clr_i = 1'b0, tx_ready_i = 1'b0, rx_valid_i = 1'b0, rx_last_i = 1'b0;
    logic [7:0] cnt_wdata_i = '0, blk_wdata_i = '0, rx_data_i = '0;
    logic [7:0] blk_rdata_o, count_o, tx_data_o;
    logic       busy_o, byte_done_o, done_o, dev_err_o, tx_valid_o, tx_last_o;
    logic       rx_ready_o, stop_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [40];

    always #10 clk = ~clk;

    smb_blk_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .buffered_i(buffered_i),
        .read_i(read_i), .i2c_rd_i(i2c_rd_i), .last_byte_i(last_byte_i),
        .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .blk_we_i(blk_we_i),
        .blk_wdata_i(blk_wdata_i), .blk_re_i(blk_re_i), .blk_rdata_o(blk_rdata_o),
        .bd_clr_i(bd_clr_i), .busy_o(busy_o), .byte_done_o(byte_done_o),
        .done_o(done_o), .dev_err_o(dev_err_o), .count_o(count_o),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
        .tx_ready_i(tx_ready_i), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .rx_last_i(rx_last_i), .rx_ready_o(rx_ready_o), .stop_o(stop_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic sw_start(input logic b, input logic r, input logic i);
        buffered_i = b; read_i = r; i2c_rd_i = i; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic sw_count(input logic [7:0] n);
        cnt_we_i = 1'b1; cnt_wdata_i = n;
        @(negedge clk); cnt_we_i = 1'b0;
    endtask

    task automatic sw_wr(input logic [7:0] d);
        blk_we_i = 1'b1; blk_wdata_i = d;
        @(negedge clk); blk_we_i = 1'b0;
    endtask

    task automatic sw_rd(output logic [7:0] d);
        d = blk_rdata_o; blk_re_i = 1'b1;
        @(negedge clk); blk_re_i = 1'b0;
    endtask

    task automatic sw_clr();
        bd_clr_i = 1'b1;
        @(negedge clk); bd_clr_i = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] d, input logic last);
        rx_valid_i = 1'b1; rx_data_i = d; rx_last_i = last;
        @(negedge clk); rx_valid_i = 1'b0; rx_last_i = 1'b0;
    endtask

    task automatic tx_expect(input int n, input string req);
        int got = 0;
        for (int g = 0; g < 200 && got < n; g++) begin
            if (tx_valid_o && tx_ready_i) begin
                check({req, " tx byte"}, tx_data_o, exp_q[got]);
                check({req, " tx last"}, tx_last_o, (got == n - 1) ? 1 : 0);
                got++;
            end
            @(negedge clk);
        end
        check({req, " tx count"}, got, n);
    endtask

    task automatic t_reset();
        check("R1 busy", busy_o, 0);
        check("R1 byte done", byte_done_o, 0);
        check("R1 done", done_o, 0);
        check("R1 err", dev_err_o, 0);
        check("R1 count", count_o, 0);
        check("R1 tx valid", tx_valid_o, 0);
        check("R1 rx ready", rx_ready_o, 0);
        check("R1 stop", stop_o, 0);
    endtask

    task automatic t_buf_write();
        logic [7:0] d0;
        buffered_i = 1'b1; read_i = 1'b0;
        sw_count(8'd5);
        for (int i = 0; i < 5; i++) begin
            exp_q[i] = 8'hA0 + 8'(i);
            sw_wr(exp_q[i]);
        end
        tx_ready_i = 1'b0;
        sw_start(1'b1, 1'b0, 1'b0);
        check("R2 busy", busy_o, 1);
        d0 = tx_data_o;
        @(negedge clk);
        check("R10 data held", tx_data_o, d0);
        check("R10 valid held", tx_valid_o, 1);
        tx_ready_i = 1'b1;
        tx_expect(5, "R2");
        check("R2 done", done_o, 1);
        check("R2 busy clear", busy_o, 0);
    endtask

    task automatic t_buf_mismatch();
        sw_count(8'd3);
        sw_wr(8'h01);
        sw_wr(8'h02);
        sw_start(1'b1, 1'b0, 1'b0);
        check("R3 err", dev_err_o, 1);
        check("R3 busy", busy_o, 0);
        check("R3 no tx", tx_valid_o, 0);
        for (int i = 0; i < 3; i++) begin
            exp_q[i] = 8'h11 + 8'(i);
            sw_wr(exp_q[i]);
        end
        sw_start(1'b1, 1'b0, 1'b0);
        check("R3 err cleared", dev_err_o, 0);
        tx_expect(3, "R3 index reset");
    endtask

    task automatic t_buf_read();
        logic [7:0] d;
        sw_start(1'b1, 1'b1, 1'b0);
        check("R4 rx ready", rx_ready_o, 1);
        for (int i = 0; i < 4; i++) rx_put(8'h30 + 8'(i), i == 3);
        check("R4 count", count_o, 4);
        check("R4 done", done_o, 1);
        check("R4 busy", busy_o, 1);
        sw_count(8'd9);
        check("R11 count ignored", count_o, 4);
        for (int i = 0; i < 4; i++) begin
            sw_rd(d);
            check("R4 read data", d, 8'h30 + i);
            check("R4 busy", busy_o, (i == 3) ? 0 : 1);
        end
    endtask

    task automatic t_byte_write();
        buffered_i = 1'b0;
        sw_count(8'd3);
        sw_wr(8'h51);
        sw_start(1'b0, 1'b0, 1'b0);
        check("R5 busy", busy_o, 1);
        check("R5 byte done", byte_done_o, 1);
        sw_wr(8'h52);
        sw_clr();
        check("R5 byte done again", byte_done_o, 1);
        sw_wr(8'h53);
        sw_clr();
        exp_q[0] = 8'h51; exp_q[1] = 8'h52; exp_q[2] = 8'h53;
        sw_clr();
        check("R5 byte done clear", byte_done_o, 0);
        tx_expect(3, "R5");
        check("R5 done", done_o, 1);
        check("R5 busy clear", busy_o, 0);
    endtask

    task automatic t_byte_read();
        last_byte_i = 1'b0;
        sw_start(1'b0, 1'b1, 1'b0);
        rx_put(8'h61, 1'b0);
        check("R6 data", blk_rdata_o, 8'h61);
        check("R6 byte done", byte_done_o, 1);
        sw_clr();
        check("R6 fetch again", rx_ready_o, 1);
        rx_put(8'h62, 1'b0);
        check("R6 data 2", blk_rdata_o, 8'h62);
        last_byte_i = 1'b1;
        sw_clr();
        rx_valid_i = 1'b1; rx_data_i = 8'h63;
        #1 check("R7 no stop for smbus read", stop_o, 0);
        @(negedge clk); rx_valid_i = 1'b0;
        check("R7 done", done_o, 1);
        check("R7 busy clear", busy_o, 0);
        check("R7 final data", blk_rdata_o, 8'h63);
        last_byte_i = 1'b0;
    endtask

    task automatic t_i2c_read();
        sw_start(1'b1, 1'b1, 1'b1);
        check("R6 i2c fetch", rx_ready_o, 1);
        rx_put(8'h71, 1'b0);
        check("R6 i2c data", blk_rdata_o, 8'h71);
        last_byte_i = 1'b1;
        sw_clr();
        rx_valid_i = 1'b1; rx_data_i = 8'h72;
        #1 check("R7 i2c stop", stop_o, 1);
        @(negedge clk); rx_valid_i = 1'b0;
        check("R7 stop one cycle", stop_o, 0);
        check("R7 i2c done", done_o, 1);
        check("R7 i2c busy clear", busy_o, 0);
        buffered_i = 1'b0; last_byte_i = 1'b0;
        #1 check("R7 i2c final data", blk_rdata_o, 8'h72);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        sw_start(1'b0, 1'b1, 1'b1);
        rx_put(8'h81, 1'b0);
        buffered_i = 1'b0; read_i = 1'b1; i2c_rd_i = 1'b0; start_i = 1'b1;
        #1 check("R8 stop on abort", stop_o, 1);
        @(negedge clk); start_i = 1'b0;
        check("R8 restarted busy", busy_o, 1);
        check("R8 byte done cleared", byte_done_o, 0);
        check("R8 fetching", rx_ready_o, 1);
        sw_start(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) rx_put(8'hC0 + 8'(i), i == 3);
        sw_rd(d);
        sw_rd(d);
        check("R4 second byte", d, 8'hC1);
        sw_start(1'b1, 1'b0, 1'b0);
        check("R8 abort drain", busy_o, 0);
        sw_rd(d);
        check("R8 index reset", d, 8'hC0);
    endtask

    task automatic t_wrap();
        sw_count(8'd7);
        sw_start(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 33; i++) sw_wr((i == 32) ? 8'hEE : (8'h40 + 8'(i)));
        sw_count(8'd1);
        exp_q[0] = 8'hEE;
        tx_ready_i = 1'b1;
        sw_start(1'b1, 1'b0, 1'b0);
        check("R9 wrap start ok", dev_err_o, 0);
        tx_expect(1, "R9 wrapped entry 0");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_buf_write();
        t_buf_mismatch();
        t_buf_read();
        t_byte_write();
        t_byte_read();
        t_i2c_read();
        t_abort();
        t_wrap();
        summary();
    end

endmodule